// File: doc/BRIEF.md
# Dual-Phase Serial Audio Transmitter

This block turns parallel audio words into a serial bit stream, most significant bit first, paced by an external bit clock and framed by a frame-sync pulse. A frame holds one or two phases. Each phase has its own word count and word length, so a stereo frame can carry, for example, one short word followed by two long ones. A static 32-bit configuration word selects the phase layout, the word lengths, a start offset of zero or one bit after frame sync, and whether an early frame sync is honoured or ignored.

Software or a DMA engine feeds words through a one-entry write register. A request output shows when that register can take a word. If a word is needed and none is waiting, the previous word goes out again and an underrun flag is raised. A frame sync that arrives in the middle of a frame, while the ignore option is off, restarts the frame and raises a sticky sync-error flag. A transmitter run input holds the shifter idle and clears both flags while it is low. The bit clock and frame sync are oversampled in the system clock domain and must come from a generator in that domain.

Top module: `txs_serial_tx`

## Requirements
- R1: While `xrst_en` is low, `sdata`, `req`, `sync_err` and `underrun` are low, one cycle later at most, and the write register is emptied.
- R2: After `xrst_en` rises, `req` stays low and no bit is shifted until one transition of `bclk` has been seen.
- R3: Once the transmitter is armed, `req` is high whenever the write register is empty. A write through `wr_en` fills the register, and `req` falls on the next cycle.
- R4: The word length code is `ctrl[7:5]` for phase one and `ctrl[23:21]` for phase two. The codes are 0=8, 1=12, 2=16, 3=20, 4=24, and any other value gives 32 bits. A word is taken from the low bits of the written value, and one bit goes out per drive edge, MSB first.
- R5: `fsync` is sampled only on drive edges. With `ctrl[17:16]` equal to 0, the MSB appears at the frame-sync edge. With any other value, the line is low at that edge and the MSB appears one drive edge later.
- R6: `ctrl[31]` set makes a two-phase frame: `ctrl[14:8]+1` words of phase one, then directly `ctrl[30:24]+1` words of phase two. With `ctrl[31]` clear, only phase one is sent and the phase-two fields have no effect.
- R7: `sdata` is low from the drive edge after the last bit of a frame until the next frame starts.
- R8: With `clk_pol` at 1, bits change on falling `bclk` edges. With `clk_pol` at 0, they change on rising edges.
- R9: When a word is due and the write register is empty, the previous word is sent again and `underrun` rises and stays high until reset.
- R10: With `ctrl[18]` clear, a frame sync on a drive edge before the last bit of the frame restarts the frame at once and sets `sync_err`, which stays set until reset.
- R11: With `ctrl[18]` set, a frame sync before the last bit of the frame is ignored. The frame continues unchanged and `sync_err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xrst_en | input | 1 | Transmitter run; low holds the shifter idle and clears the flags |
| ctrl | input | 32 | Frame configuration word |
| clk_pol | input | 1 | Drive-edge select: 1 falling, 0 rising |
| bclk | input | 1 | Bit clock, oversampled by clk |
| fsync | input | 1 | Active-high frame sync |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 32 | Word to transmit, LSB-aligned |
| req | output | 1 | Data register empty and transmitter armed |
| sdata | output | 1 | Serial data line |
| sync_err | output | 1 | Sticky unexpected-frame-sync flag |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench builds the block with its default 32-bit data path. That covers every length code from 8 to 32 bits, and a phase-two word can be as wide as the register. The bench toggles the bit clock every four system cycles, which leaves room to sample the line two cycles after each drive edge and to change the polarity between runs. With the one-entry write register, a feed that is left short produces an underrun directly. A frame sync placed on a chosen bit shows both the restart and the ignore behaviour.

// File: rtl/txs_pkg.sv
`timescale 1ns/1ps
package txs_pkg;
    localparam int DATA_W  = 32;
    localparam int BIDX_W  = $clog2(DATA_W);
    localparam int WCNT_W  = 7;
    localparam int CODE_W  = 3;

    // configuration word field positions
    localparam int P1_CODE_LSB = 5;
    localparam int P1_CNT_LSB  = 8;
    localparam int DLY_LSB     = 16;
    localparam int IGN_BIT     = 18;
    localparam int P2_CODE_LSB = 21;
    localparam int P2_CNT_LSB  = 24;
    localparam int TWO_BIT     = 31;

    typedef struct packed {
        logic              active;
        logic              pend;
        logic              phase;
        logic [WCNT_W-1:0] wcnt;
        logic [BIDX_W-1:0] bidx;
        logic [DATA_W-1:0] cur;
        logic              sdata;
        logic              serr;
        logic              urun;
    } seq_t;

    // index of the first (most significant) bit for a length code
    function automatic logic [BIDX_W-1:0] top_bit(input logic [CODE_W-1:0] code);
        case (code)
            3'd0:    top_bit = BIDX_W'(7);
            3'd1:    top_bit = BIDX_W'(11);
            3'd2:    top_bit = BIDX_W'(15);
            3'd3:    top_bit = BIDX_W'(19);
            3'd4:    top_bit = BIDX_W'(23);
            default: top_bit = BIDX_W'(DATA_W - 1);
        endcase
    endfunction
endpackage

// File: rtl/txs_edge.sv
`timescale 1ns/1ps
module txs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic xrst_en,
    input  logic clk_pol,
    input  logic bclk,
    output logic armed,
    output logic drive
);
    logic bclk_d, bclk_q;
    logic armed_d, armed_q;

    always_comb begin
        bclk_d  = bclk;
        armed_d = xrst_en & (armed_q | (bclk ^ bclk_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            bclk_q  <= bclk_d;
            armed_q <= armed_d;
        end
    end

    assign armed = armed_q;
    assign drive = armed_q & xrst_en &
                   (clk_pol ? (bclk_q & ~bclk) : (~bclk_q & bclk));
endmodule

// File: rtl/txs_hold.sv
`timescale 1ns/1ps
module txs_hold #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);
    logic         full_d, full_q;
    logic [W-1:0] data_d, data_q;

    always_comb begin
        full_d = full_q;
        data_d = data_q;
        if (clr) begin
            full_d = 1'b0;
        end else begin
            if (take)  full_d = 1'b0;
            if (wr_en) begin
                full_d = 1'b1;
                data_d = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            full_q <= full_d;
            data_q <= data_d;
        end
    end

    assign full = full_q;
    assign data = data_q;
endmodule

// File: rtl/txs_serial_tx.sv
`timescale 1ns/1ps
module txs_serial_tx
    import txs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xrst_en,
    input  logic [31:0]       ctrl,
    input  logic              clk_pol,
    input  logic              bclk,
    input  logic              fsync,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              req,
    output logic              sdata,
    output logic              sync_err,
    output logic              underrun
);
    logic              armed, drive;
    logic              hold_full, take;
    logic [DATA_W-1:0] hold_data;

    txs_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .xrst_en (xrst_en),
        .clk_pol (clk_pol),
        .bclk    (bclk),
        .armed   (armed),
        .drive   (drive)
    );

    txs_hold #(.W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (~xrst_en),
        .wr_en   (wr_en & xrst_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    // configuration fields
    logic              two_ph, ign, dly_on;
    logic [WCNT_W-1:0] cnt1, cnt2, cnt_now;
    logic [BIDX_W-1:0] len1, len2, len_now;

    assign two_ph  = ctrl[TWO_BIT];
    assign ign     = ctrl[IGN_BIT];
    assign dly_on  = |ctrl[DLY_LSB +: 2];
    assign cnt1    = ctrl[P1_CNT_LSB +: WCNT_W];
    assign cnt2    = ctrl[P2_CNT_LSB +: WCNT_W];
    assign len1    = top_bit(ctrl[P1_CODE_LSB +: CODE_W]);
    assign len2    = top_bit(ctrl[P2_CODE_LSB +: CODE_W]);

    seq_t seq_d, seq_q;
    logic busy, at_last, accept, load;
    logic [BIDX_W-1:0] load_idx;

    assign cnt_now = seq_q.phase ? cnt2 : cnt1;
    assign len_now = seq_q.phase ? len2 : len1;
    assign busy    = seq_q.active | seq_q.pend;
    assign at_last = seq_q.active & ~seq_q.pend & (seq_q.bidx == '0) &
                     (seq_q.wcnt == cnt_now) & (seq_q.phase | ~two_ph);
    assign accept  = fsync & (~busy | at_last | ~ign);

    always_comb begin
        seq_d    = seq_q;
        load     = 1'b0;
        load_idx = '0;
        if (!xrst_en) begin
            seq_d = '0;
        end else if (drive) begin
            if (accept) begin
                if (busy && !at_last) seq_d.serr = 1'b1;
                seq_d.active = 1'b1;
                seq_d.phase  = 1'b0;
                seq_d.wcnt   = '0;
                seq_d.pend   = dly_on;
                if (!dly_on) begin
                    load     = 1'b1;
                    load_idx = len1;
                end
            end else if (seq_q.pend) begin
                seq_d.pend = 1'b0;
                load       = 1'b1;
                load_idx   = len1;
            end else if (seq_q.active) begin
                if (seq_q.bidx != '0) begin
                    seq_d.bidx = seq_q.bidx - BIDX_W'(1);
                end else if (seq_q.wcnt != cnt_now) begin
                    seq_d.wcnt = seq_q.wcnt + WCNT_W'(1);
                    load       = 1'b1;
                    load_idx   = len_now;
                end else if (!seq_q.phase && two_ph) begin
                    seq_d.phase = 1'b1;
                    seq_d.wcnt  = '0;
                    load        = 1'b1;
                    load_idx    = len2;
                end else begin
                    seq_d.active = 1'b0;
                end
            end
        end
        take = load & hold_full;
        if (load) begin
            seq_d.bidx = load_idx;
            if (hold_full) seq_d.cur  = hold_data;
            else           seq_d.urun = 1'b1;
        end
        seq_d.sdata = seq_d.active & ~seq_d.pend & seq_d.cur[seq_d.bidx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign req      = armed & ~hold_full;
    assign sdata    = seq_q.sdata;
    assign sync_err = seq_q.serr;
    assign underrun = seq_q.urun;
endmodule

// File: rtl/txs_checker.sv
`timescale 1ns/1ps
module txs_checker (
    input logic clk,
    input logic rst_n,
    input logic xrst_en,
    input logic bclk,
    input logic wr_en,
    input logic req,
    input logic sdata,
    input logic sync_err,
    input logic underrun
);
    a_r1_idle_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !xrst_en |=> (!sdata && !req && !sync_err && !underrun));

    a_r3_req_drops_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wr_en) |=> !req);

    a_r8_line_moves_after_bclk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sdata != $past(sdata)) && $past(xrst_en)) |-> ($past(bclk) != $past(bclk, 2)));

    a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (xrst_en && underrun) |=> underrun);

    a_r10_sync_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (xrst_en && sync_err) |=> sync_err);
endmodule

bind txs_serial_tx txs_checker u_chk (.*);

// File: tb/txs_serial_tx_test.sv
`timescale 1ns/1ps
module txs_serial_tx_test;
    logic        clk = 1'b0;
    logic        rst_n, xrst_en, clk_pol, bclk, fsync, wr_en;
    logic [31:0] ctrl, wr_data;
    logic        req, sdata, sync_err, underrun;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic        exp_q[$];
    string       tag_q[$];
    logic [31:0] feed_q[$];
    logic [31:0] wbuf[8];
    event        drv_ev;

    txs_serial_tx uut (
        .clk(clk), .rst_n(rst_n), .xrst_en(xrst_en), .ctrl(ctrl),
        .clk_pol(clk_pol), .bclk(bclk), .fsync(fsync), .wr_en(wr_en),
        .wr_data(wr_data), .req(req), .sdata(sdata),
        .sync_err(sync_err), .underrun(underrun)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tg, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tg, act, exp, $time);
        end
    endtask

    // bit clock: toggles every 4 system cycles on a falling clk edge
    initial begin
        bclk = 1'b0;
        forever begin
            repeat (4) @(negedge clk);
            bclk = ~bclk;
            if (bclk == ~clk_pol) -> drv_ev;
        end
    end

    // driver for the write register
    initial begin
        wr_en = 1'b0;
        wr_data = '0;
        forever begin
            @(negedge clk);
            wr_en = 1'b0;
            if (req && feed_q.size() != 0) begin
                wr_data = feed_q.pop_front();
                wr_en = 1'b1;
            end
        end
    end

    // monitor: compares the line two cycles after each drive edge
    initial begin
        forever begin
            @(drv_ev);
            repeat (2) @(negedge clk);
            while (exp_q.size() != 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(sdata === e, t, {31'b0, sdata}, {31'b0, e});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int lenof(input logic [2:0] c);
        case (c)
            3'd0: lenof = 8;
            3'd1: lenof = 12;
            3'd2: lenof = 16;
            3'd3: lenof = 20;
            3'd4: lenof = 24;
            default: lenof = 32;
        endcase
    endfunction

    function automatic logic [31:0] mk(input bit two, input int n2, input logic [2:0] c2,
                                       input bit ign, input int dly, input int n1, input logic [2:0] c1);
        logic [31:0] v = '0;
        v[31] = two; v[30:24] = 7'(n2 - 1); v[23:21] = c2; v[18] = ign;
        v[17:16] = 2'(dly); v[14:8] = 7'(n1 - 1); v[7:5] = c1;
        return v;
    endfunction

    task automatic step(input logic fs, input logic e, input string tg);
        fsync = fs;
        @(drv_ev);
        exp_q.push_back(e);
        tag_q.push_back(tg);
        @(negedge clk);
        fsync = 1'b0;
    endtask

    task automatic align();
        @(drv_ev);
        @(negedge clk);
    endtask

    task automatic play(input int nfeed, input string tg);
        bit two = ctrl[31];
        int k = 0;
        bit first = 1;
        for (int i = 0; i < nfeed; i++) feed_q.push_back(wbuf[i]);
        align();
        if (ctrl[17:16] != 0) begin
            step(1'b1, 1'b0, "R5");
            first = 0;
        end
        for (int ph = 0; ph < (two ? 2 : 1); ph++) begin
            int n = ph ? int'(ctrl[30:24]) + 1 : int'(ctrl[14:8]) + 1;
            int l = lenof(ph ? ctrl[23:21] : ctrl[7:5]);
            for (int w = 0; w < n; w++) begin
                for (int b = l - 1; b >= 0; b--) begin
                    step(first, wbuf[k][b], tg);
                    first = 0;
                end
                k++;
            end
        end
        step(1'b0, 1'b0, "R7");
        step(1'b0, 1'b0, "R7");
    endtask

    task automatic restart_tx();
        @(negedge clk);
        xrst_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(!sync_err && !underrun && !req && !sdata, "R1", {sync_err, underrun, req, sdata}, 0);
        xrst_en = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; xrst_en = 1'b0; clk_pol = 1'b1; fsync = 1'b0; ctrl = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!sdata && !req && !sync_err && !underrun, "R1", {sdata, req, sync_err, underrun}, 0);

        // arming: enable just after a bclk transition, then watch req
        align();
        xrst_en = 1'b1;
        @(negedge clk);
        chk(req == 1'b0, "R2", req, 0);
        repeat (4) @(negedge clk);
        chk(req == 1'b1, "R2", req, 1);

        // R3: write fills register, req falls next cycle
        feed_q.push_back(32'h0000_1234);
        @(negedge clk);
        @(negedge clk);
        chk(req == 1'b0, "R3", req, 0);
        restart_tx();

        // single phase, 16-bit words, one-bit delay
        ctrl = mk(0, 1, 3'd0, 0, 1, 2, 3'd2);
        wbuf[0] = 32'hFFFF_A5C3; wbuf[1] = 32'h0000_3C96;
        play(2, "R4");
        chk(underrun == 1'b0, "R9", underrun, 0);

        // zero delay, 8-bit words, three per frame
        ctrl = mk(0, 1, 3'd0, 0, 0, 3, 3'd0);
        wbuf[0] = 32'h1234_56B1; wbuf[1] = 32'h0000_004E; wbuf[2] = 32'hFFFF_FFD2;
        play(3, "R5");

        // two-phase: one 8-bit word then two 32-bit words
        ctrl = mk(1, 2, 3'd5, 0, 1, 1, 3'd0);
        wbuf[0] = 32'h0000_00C7; wbuf[1] = 32'hDEAD_BEEF; wbuf[2] = 32'h8001_7FFE;
        play(3, "R6");

        // phase-two fields set but two-phase off: one 12-bit word only
        ctrl = mk(0, 3, 3'd4, 0, 0, 1, 3'd1);
        wbuf[0] = 32'hABCD_E9A6;
        play(1, "R6");

        // 20-bit and 24-bit lengths
        ctrl = mk(0, 1, 3'd0, 0, 1, 1, 3'd3);
        wbuf[0] = 32'hFFF8_1F3C;
        play(1, "R4");
        ctrl = mk(0, 1, 3'd0, 0, 0, 1, 3'd4);
        wbuf[0] = 32'h00A3_5C71;
        play(1, "R4");

        // rising-edge drive
        @(negedge clk);
        xrst_en = 1'b0;
        clk_pol = 1'b0;
        repeat (2) @(negedge clk);
        xrst_en = 1'b1;
        repeat (12) @(negedge clk);
        ctrl = mk(0, 1, 3'd0, 0, 1, 2, 3'd2);
        wbuf[0] = 32'h0000_96A5; wbuf[1] = 32'h0000_0F1E;
        play(2, "R8");
        @(negedge clk);
        xrst_en = 1'b0;
        clk_pol = 1'b1;
        repeat (2) @(negedge clk);
        xrst_en = 1'b1;
        repeat (12) @(negedge clk);

        // underrun: two words due, one fed; first repeats
        ctrl = mk(0, 1, 3'd0, 0, 1, 2, 3'd2);
        wbuf[0] = 32'h0000_C35A; wbuf[1] = 32'h0000_C35A;
        play(1, "R9");
        chk(underrun == 1'b1, "R9", underrun, 1);
        repeat (20) @(negedge clk);
        chk(underrun == 1'b1, "R9", underrun, 1);
        restart_tx();

        // early sync with ignore off: restart and flag
        ctrl = mk(0, 1, 3'd0, 0, 0, 2, 3'd0);
        wbuf[0] = 32'h0000_00B4; wbuf[1] = 32'h0000_0067; wbuf[2] = 32'h0000_00E9;
        for (int i = 0; i < 3; i++) feed_q.push_back(wbuf[i]);
        align();
        step(1'b1, wbuf[0][7], "R10");
        step(1'b0, wbuf[0][6], "R10");
        step(1'b0, wbuf[0][5], "R10");
        step(1'b1, wbuf[1][7], "R10");
        for (int b = 6; b >= 0; b--) step(1'b0, wbuf[1][b], "R10");
        for (int b = 7; b >= 0; b--) step(1'b0, wbuf[2][b], "R10");
        step(1'b0, 1'b0, "R7");
        chk(sync_err == 1'b1, "R10", sync_err, 1);
        chk(underrun == 1'b0, "R10", underrun, 0);
        restart_tx();

        // early sync with ignore on: frame continues
        ctrl = mk(0, 1, 3'd0, 1, 0, 2, 3'd0);
        wbuf[0] = 32'h0000_005D; wbuf[1] = 32'h0000_00A2;
        for (int i = 0; i < 2; i++) feed_q.push_back(wbuf[i]);
        align();
        step(1'b1, wbuf[0][7], "R11");
        step(1'b0, wbuf[0][6], "R11");
        step(1'b1, wbuf[0][5], "R11");
        for (int b = 4; b >= 0; b--) step(1'b0, wbuf[0][b], "R11");
        for (int b = 7; b >= 0; b--) step(1'b0, wbuf[1][b], "R11");
        step(1'b0, 1'b0, "R7");
        chk(sync_err == 1'b0, "R11", sync_err, 0);

        repeat (8) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule